// File: doc/BRIEF.md
# Two-Wire Keyboard Frame Receiver

This block is the host-side receiver for a keyboard link made of two open-drain lines: a clock that the keyboard drives and a data line that both ends may pull low. It brings both lines into the system clock domain. It sees the start of a frame as a falling edge on the keyboard clock. It then captures nine bits, each one read partway through the clock-high phase, and waits for the keyboard to drop the data line as the stop mark. Timing is measured in microsecond ticks, which come from a prescaler on the system clock.

Each finished frame gives one byte on a valid/ready stream output, along with a flag that reports bad odd parity. The output holds a single entry. Back-pressure works as follows. While an entry waits unaccepted, the block pulls the data line low, and this stops the keyboard from starting a new frame. The entry, with its byte and parity flag, stays unchanged until the cycle in which `m_valid` and `m_ready` are both high. A software `inhibit_i` input pulls the data line low in the same way. A frame that stalls, or whose clock drops too early, is dropped and reported on a one-cycle error pulse.

Top module: `kbd_frame_rx`

## Requirements
- R1: Frame bits are taken least significant first: the first eight captured bits form `m_data` (first bit in bit 0), the ninth is the parity bit.
- R2: Parity is odd: `m_perr` is 1 exactly when the eight data bits plus the parity bit hold an even number of ones.
- R3: A falling keyboard-clock edge while idle and not blocking starts a frame; the start phase (clock low) may last up to `TIMEOUT_US` microsecond ticks without error.
- R4: Each bit is captured `SAMPLE_US` ticks after the rising clock edge that opens its high phase.
- R5: After the ninth bit the frame completes when the data line is seen low with the clock high; `m_valid` then rises.
- R6: While `m_valid` is high and `m_ready` low, `m_valid`, `m_data` and `m_perr` hold; a cycle with both high clears `m_valid`.
- R7: `kdat_pull_o` is high whenever `inhibit_i` is high or an output entry is pending.
- R8: A frame whose start edge arrives while `kdat_pull_o` is high is ignored: no output entry is produced and a pending entry is not altered.
- R9: In a frame, `TIMEOUT_US` ticks with no clock edge abort it: one-cycle `frame_err_o` pulse, no output entry.
- R10: A falling clock edge before a bit's capture point aborts the frame with a one-cycle `frame_err_o` pulse and no output entry.
- R11: After reset `m_valid`, `kdat_pull_o` and `frame_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kclk_i | input | 1 | Keyboard clock line level (asynchronous) |
| kdat_i | input | 1 | Keyboard data line level (asynchronous) |
| inhibit_i | input | 1 | Request to block keyboard transmission |
| kdat_pull_o | output | 1 | 1 = pull the data line low |
| m_valid | output | 1 | Received entry available |
| m_ready | input | 1 | Consumer accepts the entry |
| m_data | output | 8 | Received byte |
| m_perr | output | 1 | Odd-parity check failed for this byte |
| frame_err_o | output | 1 | One-cycle pulse on an aborted frame |

## Verification
Assertions watch on every cycle that a held entry stays stable under back-pressure, that no frame completes into an occupied slot, that the receiver never leaves idle while it is blocking the line, that each abort returns it to idle, and that the microsecond tick never fires on two cycles in a row. Only the bench scenarios can show that the bytes and parity flags are correct for all 256 values. The bench scenarios also cover the long start phase that is accepted, stalled and truncated frames that give one error each, and frames sent while the line is blocked, which must leave no trace at the output.

// File: rtl/kfr_pkg.sv
package kfr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HIGH,
    ST_WAITF,
    ST_LOW,
    ST_STOP
  } rx_state_t;
endpackage

// File: rtl/kfr_sync.sv
module kfr_sync #(
  parameter int          WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end
endmodule

// File: rtl/kfr_tick.sv
module kfr_tick #(
  parameter int CLK_PER_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  if (CLK_PER_US > 1) begin : g_spacing
    // R4: tick spacing underpins all microsecond timing
    p_tick_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/kfr_deframe.sv
module kfr_deframe
  import kfr_pkg::*;
#(
  parameter int SAMPLE_US  = 30,
  parameter int TIMEOUT_US = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       kclk_s,
  input  logic       kdat_s,
  input  logic       block_i,
  output logic       done_o,
  output logic [7:0] byte_o,
  output logic       perr_o,
  output logic       err_o
);
  localparam int TW = $clog2(TIMEOUT_US + 1);
  localparam logic [TW-1:0] TO_LAST  = TW'(TIMEOUT_US - 1);
  localparam logic [TW-1:0] SMP_LAST = TW'(SAMPLE_US - 1);
  localparam int NBITS = 9;

  rx_state_t      st_q;
  logic           ck_q;
  logic [TW-1:0]  tcnt_q;
  logic [NBITS-1:0] shreg_q;
  logic [3:0]     nbit_q;
  logic           rise, fall;

  assign rise = kclk_s & ~ck_q;
  assign fall = ~kclk_s & ck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ck_q    <= 1'b1;
      tcnt_q  <= '0;
      shreg_q <= '0;
      nbit_q  <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      ck_q   <= kclk_s;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          tcnt_q <= '0;
          nbit_q <= '0;
          if (fall && !block_i) st_q <= ST_START;
        end
        ST_START, ST_LOW: begin
          if (rise) begin
            st_q   <= ST_HIGH;
            tcnt_q <= '0;
          end else if (tick_i) begin
            if (tcnt_q == TO_LAST) begin
              st_q  <= ST_IDLE;
              err_o <= 1'b1;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_HIGH: begin
          if (fall) begin
            st_q  <= ST_IDLE;
            err_o <= 1'b1;
          end else if (tick_i) begin
            if (tcnt_q == SMP_LAST) begin
              shreg_q <= {kdat_s, shreg_q[NBITS-1:1]};
              nbit_q  <= nbit_q + 1'b1;
              tcnt_q  <= '0;
              st_q    <= (nbit_q == 4'(NBITS - 1)) ? ST_STOP : ST_WAITF;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_WAITF: begin
          if (fall) begin
            st_q   <= ST_LOW;
            tcnt_q <= '0;
          end else if (tick_i) begin
            if (tcnt_q == TO_LAST) begin
              st_q  <= ST_IDLE;
              err_o <= 1'b1;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (!kdat_s && kclk_s) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end else if (fall) begin
            st_q  <= ST_IDLE;
            err_o <= 1'b1;
          end else if (tick_i) begin
            if (tcnt_q == TO_LAST) begin
              st_q  <= ST_IDLE;
              err_o <= 1'b1;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign byte_o = shreg_q[7:0];
  assign perr_o = ~^shreg_q;

  // R8: a blocked line keeps the receiver idle
  p_blocked_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && block_i) |=> st_q == ST_IDLE);
  // R9: an abort always lands in idle
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> st_q == ST_IDLE);
  // R5: completion and abort never coincide
  p_done_xor_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
endmodule

// File: rtl/kfr_out_slot.sv
module kfr_out_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          perr_i,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [DW-1:0] data_o,
  output logic          perr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      perr_o  <= perr_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R6: held entry is stable under back-pressure
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o && $stable(data_o) && $stable(perr_o));
  // R8: no frame completes into an occupied slot
  p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !valid_o);
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
  parameter int CLK_PER_US = 200,
  parameter int SAMPLE_US  = 30,
  parameter int TIMEOUT_US = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kclk_i,
  input  logic       kdat_i,
  input  logic       inhibit_i,
  output logic       kdat_pull_o,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_perr,
  output logic       frame_err_o
);
  logic [1:0] lines_s;
  logic       tick;
  logic       done;
  logic [7:0] rx_byte;
  logic       rx_perr;

  kfr_sync #(.WIDTH(2), .RST_VAL(2'b01)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .async_i({kdat_i, kclk_i}), .sync_o(lines_s)
  );

  kfr_tick #(.CLK_PER_US(CLK_PER_US)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  assign kdat_pull_o = inhibit_i | m_valid;

  kfr_deframe #(.SAMPLE_US(SAMPLE_US), .TIMEOUT_US(TIMEOUT_US)) deframe_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .kclk_s(lines_s[0]), .kdat_s(lines_s[1]), .block_i(kdat_pull_o),
    .done_o(done), .byte_o(rx_byte), .perr_o(rx_perr), .err_o(frame_err_o)
  );

  kfr_out_slot #(.DW(8)) slot_i (
    .clk(clk), .rst_n(rst_n), .load_i(done), .data_i(rx_byte),
    .perr_i(rx_perr), .valid_o(m_valid), .ready_i(m_ready),
    .data_o(m_data), .perr_o(m_perr)
  );

  // R7: a pending entry always blocks the keyboard
  p_pending_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> kdat_pull_o);
endmodule

// File: tb/kbd_frame_rx_tb_top.sv
module kbd_frame_rx_tb_top;
  localparam int CPU = 2;
  localparam int SMP = 6;
  localparam int TMO = 40;
  localparam int HI  = 12;
  localparam int LO  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kclk = 1'b1, kdat = 1'b0, inhibit = 1'b0, m_ready = 1'b0;
  logic kdat_pull, m_valid, m_perr, frame_err;
  logic [7:0] m_data;
  int checks = 0, errors = 0, errp = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  kbd_frame_rx #(.CLK_PER_US(CPU), .SAMPLE_US(SMP), .TIMEOUT_US(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .kclk_i(kclk), .kdat_i(kdat),
    .inhibit_i(inhibit), .kdat_pull_o(kdat_pull), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_perr(m_perr),
    .frame_err_o(frame_err)
  );

  always @(posedge clk) if (rst_n && frame_err) errp++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic us(input int n);
    repeat (n * CPU) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] b, input bit flip, input int start_us,
                       input int short_bit, input int stall_bit);
    logic [8:0] bits;
    bits = {(~^b) ^ flip, b};
    kclk = 1'b0; kdat = 1'b1;
    us(start_us);
    for (int i = 0; i < 9; i++) begin
      if (i == stall_bit) begin
        us(TMO + 20); kclk = 1'b1; kdat = 1'b0; us(4); return;
      end
      kdat = bits[i]; kclk = 1'b1;
      if (i == short_bit) begin
        us(2); kclk = 1'b0; us(2); kclk = 1'b1; kdat = 1'b0; us(4); return;
      end
      us(HI);
      if (i < 8) begin kclk = 1'b0; us(LO); end
    end
    kdat = 1'b0;
    us(4);
  endtask

  task automatic accept();
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
    @(negedge clk);
    check(m_valid == 1'b0, "R6 accept clears", m_valid, 0);
  endtask

  task automatic good_frame(input logic [7:0] b, input bit flip, input int start_us,
                            input string tag);
    int e0;
    e0 = errp;
    frame(b, flip, start_us, -1, -1);
    check(m_valid == 1'b1, {tag, " R5 valid after stop"}, m_valid, 1);
    check(m_data == b, {tag, " R1 byte"}, m_data, b);
    check(m_perr == flip, {tag, " R2 parity flag"}, m_perr, flip);
    check(errp == e0, {tag, " R9 no error"}, errp - e0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    check(m_valid == 0, "R11 valid in reset", m_valid, 0);
    check(kdat_pull == 0, "R11 pull in reset", kdat_pull, 0);
    rst_n = 1'b1;
    us(4);
    check(m_valid == 0 && frame_err == 0 && kdat_pull == 0, "R11 idle after reset",
          {m_valid, frame_err, kdat_pull}, 0);

    // R1 R2 R5: exhaustive byte sweep, R4 implied by mid-high capture
    for (int b = 0; b < 256; b++) begin
      good_frame(8'(b), 1'b0, 8, "sweep R4");
      if (b % 32 == 0) begin
        check(kdat_pull == 1'b1, "R7 pending blocks", kdat_pull, 1);
        repeat (7) @(negedge clk);
        check(m_valid && m_data == 8'(b), "R6 hold under back-pressure", m_data, b);
      end
      accept();
    end

    // R2: wrong parity reported
    for (int b = 0; b < 256; b += 17) begin
      good_frame(8'(b), 1'b1, 8, "badpar");
      accept();
    end

    // R3: long start phase tolerated
    good_frame(8'hA5, 1'b0, TMO - 5, "R3 long start");
    accept();

    // R9: stalls abort with one error pulse
    begin
      int e0;
      e0 = errp;
      frame(8'h3C, 1'b0, 8, -1, 4);
      check(errp == e0 + 1, "R9 stall mid-frame error", errp - e0, 1);
      check(m_valid == 0, "R9 no output after stall", m_valid, 0);
      e0 = errp;
      frame(8'h3C, 1'b0, 8, -1, 0);
      check(errp == e0 + 1, "R9 start too long error", errp - e0, 1);
      check(m_valid == 0, "R9 no output after long start", m_valid, 0);
      // R10: early clock fall
      e0 = errp;
      frame(8'h5A, 1'b0, 8, 3, -1);
      check(errp == e0 + 1, "R10 early fall error", errp - e0, 1);
      check(m_valid == 0, "R10 no output after early fall", m_valid, 0);
    end
    good_frame(8'h81, 1'b0, 8, "recovery");
    accept();

    // R7 R8: inhibit input blocks and frames are ignored
    inhibit = 1'b1;
    @(negedge clk);
    check(kdat_pull == 1'b1, "R7 inhibit pulls", kdat_pull, 1);
    frame(8'hFF, 1'b0, 8, -1, -1);
    check(m_valid == 0, "R8 ignored under inhibit", m_valid, 0);
    inhibit = 1'b0;
    @(negedge clk);
    check(kdat_pull == 1'b0, "R7 release", kdat_pull, 0);

    // R8: pending entry not altered by a blocked frame
    good_frame(8'h12, 1'b0, 8, "pend");
    frame(8'hEE, 1'b1, 8, -1, -1);
    check(m_valid && m_data == 8'h12 && m_perr == 0, "R8 pending unchanged", m_data, 8'h12);
    accept();
    us(4);
    check(m_valid == 0, "R8 no second entry", m_valid, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule